// File: doc/BRIEF.md
# SPI Event and Interrupt Controller

This block holds the interrupt side of an SPI controller. It sits beside the shift engine and collects that engine's live status levels and one-cycle event strobes into a single event word. It keeps an interrupt-enable word and drives one interrupt line. A small register port with an address, a write strobe, write data and combinational read data gives access to three words: the event word, the enable word and a command word.

A status condition raises the interrupt only when its event bit goes from 0 to 1 while that bit's enable is set. A bit that stays high does not raise it again. The command word has one write-only bit that arms last-character detection. Once armed, the block sets the last-character event when the final character leaves an empty transmit queue. In three-wire mode it waits for the whole transfer to finish instead. The arm is then dropped by the block itself.

The event word sits at offset 0x24, the enable word at 0x28 and the command word at 0x2C. Event bits and enable bits share the same positions: transfer busy 31, last character 14, overrun 12, underrun 11, multi-master error 10, receive not empty 9, transmit not full 8.

Top module: `spi_evt_irq_ctrl`

## Requirements
- R1: A clock edge with `rst_n` low clears the enable word, the armed state and the sticky event bits, and leaves `irq` low.
- R2: A write to offset 0x28 stores the enable bits at 31, 14, 12, 11, 10, 9 and 8, and reading 0x28 returns them. All other bits of 0x28 read as zero.
- R3: Offset 0x2C always reads zero. Writing it with bit 22 set arms last-character detection from the next edge.
- R4: While armed and not in three-wire mode, a character-done strobe with the transmit queue empty sets event bit 14 at the next edge. A character-done strobe with a non-empty queue leaves bit 14 clear.
- R5: While armed in three-wire mode, only the transfer-done strobe sets bit 14. A character-done strobe with an empty queue has no effect.
- R6: The armed state clears on the edge that sets bit 14. A second trigger after bit 14 has been cleared leaves bit 14 at zero.
- R7: Bits 14, 12, 11 and 10 are sticky. Overrun, underrun and multi-master strobes set bits 12, 11 and 10. Writing a 1 to a sticky bit at 0x24 clears it, and writing 0 leaves it as it is. A set and a clear on the same edge leave the bit at 1.
- R8: Bits 31, 9 and 8 at 0x24 show the busy, not-empty and not-full inputs as sampled at the previous edge. Writes to 0x24 do not change them.
- R9: `irq` is high for exactly one cycle after an edge on which an enabled event bit went from 0 to 1. It stays low while that bit stays high.
- R10: A 0-to-1 change of a disabled event bit does not raise `irq`. Enabling a bit that is already high does not raise it either.
- R11: Reads of any offset other than 0x24 and 0x28 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| st_busy | input | 1 | A transfer is in progress (level) |
| st_not_empty | input | 1 | The receive queue holds data (level) |
| st_not_full | input | 1 | The transmit queue has space (level) |
| st_txq_empty | input | 1 | The transmit queue is empty (level) |
| ev_overrun | input | 1 | Overrun strobe |
| ev_underrun | input | 1 | Underrun strobe |
| ev_mm_err | input | 1 | Multi-master error strobe |
| ev_char_done | input | 1 | A character finished transmitting (strobe) |
| ev_xfer_done | input | 1 | The whole transfer finished (strobe) |
| cfg_three_wire | input | 1 | Three-wire mode is selected |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions assume that the shift engine's strobes last one cycle and that every input is a defined 0 or 1 from the first clock edge, with reset held over that edge. The bench drives each input just after the rising edge and returns every strobe to zero after one cycle. It asserts reset from time zero and never changes the three-wire flag in the cycle that carries a trigger strobe.

// File: rtl/spi_evt_pkg.sv
// Package: bit positions and masks shared by the SPI event controller.
// Assumes a 32-bit register word.
package spi_evt_pkg;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned BIT_TIP = 31;
    localparam int unsigned BIT_LT  = 14;
    localparam int unsigned BIT_OV  = 12;
    localparam int unsigned BIT_UN  = 11;
    localparam int unsigned BIT_MME = 10;
    localparam int unsigned BIT_NE  = 9;
    localparam int unsigned BIT_NF  = 8;
    localparam int unsigned BIT_ARM = 22;

    localparam logic [REG_W-1:0] STICKY_BITS =
        (REG_W'(1) << BIT_LT) | (REG_W'(1) << BIT_OV) |
        (REG_W'(1) << BIT_UN) | (REG_W'(1) << BIT_MME);
    localparam logic [REG_W-1:0] LIVE_BITS =
        (REG_W'(1) << BIT_TIP) | (REG_W'(1) << BIT_NE) | (REG_W'(1) << BIT_NF);
    localparam logic [REG_W-1:0] EVT_BITS = STICKY_BITS | LIVE_BITS;
endpackage

// File: rtl/spi_evt_ctrl_regs.sv
// Enable word and last-character arm flag.
// Assumes the write strobes are already decoded by address.
module spi_evt_ctrl_regs
    import spi_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mask,
    input  logic [REG_W-1:0] wdata,
    input  logic             arm_req,
    input  logic             fire_lt,
    output logic [REG_W-1:0] mask_q,
    output logic             armed
);
    // Enable word: keeps only the defined enable positions.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata & EVT_BITS;
    end

    // Arm flag: set by command, dropped when the event it waits for fires.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (arm_req) armed <= 1'b1;
        else if (fire_lt) armed <= 1'b0;
    end

    assert_arm_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_req |=> armed);
    assert_arm_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_lt && !arm_req) |=> !armed);
endmodule

// File: rtl/spi_evt_status.sv
// Event word: sticky event bits plus registered live status bits.
// Assumes each event strobe lasts one cycle. A set wins over a clear on the same edge.
module spi_evt_status
    import spi_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] clr_vec,
    input  logic             armed,
    input  logic             cfg_three_wire,
    input  logic             ev_char_done,
    input  logic             st_txq_empty,
    input  logic             ev_xfer_done,
    input  logic             ev_overrun,
    input  logic             ev_underrun,
    input  logic             ev_mm_err,
    input  logic             st_busy,
    input  logic             st_not_empty,
    input  logic             st_not_full,
    output logic             fire_lt,
    output logic [REG_W-1:0] evt_q
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] live_d;
    logic [REG_W-1:0] live_q;
    logic [REG_W-1:0] sticky_q;

    // Last-character trigger: which completion counts depends on the mode.
    always_comb begin
        fire_lt = armed && (cfg_three_wire ? ev_xfer_done
                                           : (ev_char_done && st_txq_empty));
    end

    // Place the strobes and levels at their bit positions.
    always_comb begin
        set_vec          = '0;
        set_vec[BIT_LT]  = fire_lt;
        set_vec[BIT_OV]  = ev_overrun;
        set_vec[BIT_UN]  = ev_underrun;
        set_vec[BIT_MME] = ev_mm_err;
        live_d           = '0;
        live_d[BIT_TIP]  = st_busy;
        live_d[BIT_NE]   = st_not_empty;
        live_d[BIT_NF]   = st_not_full;
    end

    // One flop per sticky position, chosen by the package mask.
    for (genvar g = 0; g < REG_W; g++) begin : g_sticky
        if (STICKY_BITS[g]) begin : g_flop
            // Sticky bit: set by event, cleared by writing 1.
            always_ff @(posedge clk) begin
                if (!rst_n)          sticky_q[g] <= 1'b0;
                else if (set_vec[g]) sticky_q[g] <= 1'b1;
                else if (clr_vec[g]) sticky_q[g] <= 1'b0;
            end
        end else begin : g_zero
            assign sticky_q[g] = 1'b0;
        end
    end

    // Live bits: register the status levels once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    assign evt_q = sticky_q | live_q;

    assert_ov_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_overrun |=> evt_q[BIT_OV]);
    assert_lt_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !evt_q[BIT_LT]) |=> !evt_q[BIT_LT]);
    assert_lt_threewire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_three_wire && !ev_xfer_done && !evt_q[BIT_LT]) |=> !evt_q[BIT_LT]);
endmodule

// File: rtl/spi_evt_irq.sv
// Rising-edge detector on the enabled event bits. Drives a one-cycle interrupt.
// Assumes evt_q and mask_q come from registers.
module spi_evt_irq
    import spi_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_q,
    input  logic [REG_W-1:0] mask_q,
    output logic             irq
);
    logic [REG_W-1:0] prev_q;

    // Keep the event word from one cycle ago for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= evt_q;
    end

    // Interrupt: any enabled bit that has just gone from 0 to 1.
    always_comb begin
        irq = |(evt_q & ~prev_q & mask_q);
    end

    assert_irq_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (evt_q != $past(evt_q)));
    assert_irq_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((evt_q & mask_q) != '0));
endmodule

// File: rtl/spi_evt_irq_ctrl.sv
// Top: decodes the register port, joins the enable, event and interrupt logic
// and returns read data combinationally.
// Assumes the offsets are distinct and byte-aligned.
module spi_evt_irq_ctrl
    import spi_evt_pkg::*;
#(
    parameter int unsigned        ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OFS_EVT  = ADDR_W'(8'h24),
    parameter logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(8'h28),
    parameter logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'(8'h2C)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              st_busy,
    input  logic              st_not_empty,
    input  logic              st_not_full,
    input  logic              st_txq_empty,
    input  logic              ev_overrun,
    input  logic              ev_underrun,
    input  logic              ev_mm_err,
    input  logic              ev_char_done,
    input  logic              ev_xfer_done,
    input  logic              cfg_three_wire,
    output logic              irq
);
    logic             wr_evt, wr_mask, wr_cmd, arm_req, armed, fire_lt;
    logic [REG_W-1:0] clr_vec, mask_q, evt_q;

    // Address decode for writes.
    always_comb begin
        wr_evt  = reg_wr && (reg_addr == OFS_EVT);
        wr_mask = reg_wr && (reg_addr == OFS_MASK);
        wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
        arm_req = wr_cmd && reg_wdata[BIT_ARM];
        clr_vec = wr_evt ? reg_wdata : '0;
    end

    spi_evt_ctrl_regs i_regs (
        .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .wdata(reg_wdata),
        .arm_req(arm_req), .fire_lt(fire_lt), .mask_q(mask_q), .armed(armed)
    );

    spi_evt_status i_status (
        .clk(clk), .rst_n(rst_n), .clr_vec(clr_vec), .armed(armed),
        .cfg_three_wire(cfg_three_wire), .ev_char_done(ev_char_done),
        .st_txq_empty(st_txq_empty), .ev_xfer_done(ev_xfer_done),
        .ev_overrun(ev_overrun), .ev_underrun(ev_underrun), .ev_mm_err(ev_mm_err),
        .st_busy(st_busy), .st_not_empty(st_not_empty), .st_not_full(st_not_full),
        .fire_lt(fire_lt), .evt_q(evt_q)
    );

    spi_evt_irq i_irq (
        .clk(clk), .rst_n(rst_n), .evt_q(evt_q), .mask_q(mask_q), .irq(irq)
    );

    // Read mux: the command word and unmapped offsets read as zero.
    always_comb begin
        if (reg_addr == OFS_EVT)       reg_rdata = evt_q;
        else if (reg_addr == OFS_MASK) reg_rdata = mask_q;
        else                           reg_rdata = '0;
    end

    assert_rst_irq_low_R1: assert property (@(posedge clk)
        !rst_n |=> !irq);
endmodule

// File: tb/test_spi_evt_irq_ctrl.sv
`timescale 1ns/1ps
module test_spi_evt_irq_ctrl;
    localparam logic [7:0] A_EVT = 8'h24, A_MASK = 8'h28, A_CMD = 8'h2C;

    logic clk = 0, rst_n = 0;
    logic [7:0]  reg_addr = 0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic st_busy = 0, st_not_empty = 0, st_not_full = 0, st_txq_empty = 0;
    logic ev_overrun = 0, ev_underrun = 0, ev_mm_err = 0;
    logic ev_char_done = 0, ev_xfer_done = 0, cfg_three_wire = 0;
    logic irq;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spi_evt_irq_ctrl i_spi_evt_irq_ctrl (.*);

    // Reference model: one variable per bit, updated at each rising edge.
    bit m_tip, m_ne, m_nf, m_lt, m_ov, m_un, m_mme, m_arm;
    bit [31:0] m_mask, m_prev;

    function automatic bit [31:0] m_evt();
        bit [31:0] v = 0;
        v[31] = m_tip; v[14] = m_lt; v[12] = m_ov; v[11] = m_un;
        v[10] = m_mme; v[9] = m_ne; v[8] = m_nf;
        return v;
    endfunction

    always @(posedge clk) begin
        bit fire, clr;
        bit [31:0] w;
        if (!rst_n) begin
            {m_tip, m_ne, m_nf, m_lt, m_ov, m_un, m_mme, m_arm} = 0;
            m_mask = 0; m_prev = 0;
        end else begin
            m_prev = m_evt();
            clr = reg_wr && reg_addr == A_EVT;
            w = reg_wdata;
            fire = m_arm && (cfg_three_wire ? ev_xfer_done : (ev_char_done && st_txq_empty));
            if (fire) m_lt = 1; else if (clr && w[14]) m_lt = 0;
            if (ev_overrun) m_ov = 1; else if (clr && w[12]) m_ov = 0;
            if (ev_underrun) m_un = 1; else if (clr && w[11]) m_un = 0;
            if (ev_mm_err) m_mme = 1; else if (clr && w[10]) m_mme = 0;
            m_tip = st_busy; m_ne = st_not_empty; m_nf = st_not_full;
            if (reg_wr && reg_addr == A_CMD && w[22]) m_arm = 1;
            else if (fire) m_arm = 0;
            if (reg_wr && reg_addr == A_MASK) m_mask = w & 32'h8000_5F00;
        end
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) if (rst_n && !finished) begin
        bit [31:0] e;
        bit [31:0] r;
        e = m_evt();
        check("R9 irq", {31'b0, irq}, {31'b0, |(e & ~m_prev & m_mask)});
        r = (reg_addr == A_EVT) ? e : (reg_addr == A_MASK) ? m_mask : 0;
        check(reg_addr == A_MASK ? "R2 rdata" : reg_addr == A_EVT ? "R7 rdata" :
              reg_addr == A_CMD ? "R3 rdata" : "R11 rdata", reg_rdata, r);
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_addr = a; reg_wr = 1; reg_wdata = d;
        step();
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic summary();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(20ns * 100000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (3) step();
        check("R1 irq", {31'b0, irq}, 0);
        rst_n = 1;
        rd(A_MASK, v); check("R1 mask", v, 0);
        rd(A_EVT, v);  check("R1 events", v, 0);

        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, v); check("R2 mask bits", v, 32'h8000_5F00);
        wr(A_MASK, 32'h0000_4000);
        rd(A_MASK, v); check("R2 mask lt", v, 32'h0000_4000);

        rd(A_CMD, v); check("R3 cmd read", v, 0);
        wr(A_CMD, 32'h0040_0000);
        rd(A_CMD, v); check("R3 cmd after arm", v, 0);

        ev_char_done = 1; st_txq_empty = 0; step(); ev_char_done = 0;
        rd(A_EVT, v); check("R4 queue busy", v[14], 0);
        st_txq_empty = 1; ev_char_done = 1; step(); ev_char_done = 0;
        check("R9 pulse", {31'b0, irq}, 1);
        rd(A_EVT, v); check("R4 last set", v[14], 1);
        step();
        check("R9 no repeat", {31'b0, irq}, 0);

        wr(A_EVT, 32'h0000_4000);
        rd(A_EVT, v); check("R7 lt cleared", v[14], 0);
        ev_char_done = 1; step(); ev_char_done = 0;
        rd(A_EVT, v); check("R6 disarmed", v[14], 0);

        cfg_three_wire = 1;
        wr(A_CMD, 32'h0040_0000);
        ev_char_done = 1; step(); ev_char_done = 0;
        rd(A_EVT, v); check("R5 char ignored", v[14], 0);
        ev_xfer_done = 1; step(); ev_xfer_done = 0;
        check("R5 irq", {31'b0, irq}, 1);
        rd(A_EVT, v); check("R5 xfer sets", v[14], 1);
        cfg_three_wire = 0;
        wr(A_EVT, 32'h0000_4000);

        ev_overrun = 1; step(); ev_overrun = 0;
        check("R10 masked rise", {31'b0, irq}, 0);
        rd(A_EVT, v); check("R7 ov set", v[12], 1);
        wr(A_EVT, 0);
        rd(A_EVT, v); check("R7 zero write", v[12], 1);
        wr(A_EVT, 32'h0000_1000);
        rd(A_EVT, v); check("R7 ov clear", v[12], 0);
        ev_overrun = 1; wr(A_EVT, 32'h0000_1000); ev_overrun = 0;
        rd(A_EVT, v); check("R7 set wins", v[12], 1);
        wr(A_MASK, 32'h0000_5000);
        check("R10 late enable", {31'b0, irq}, 0);

        ev_underrun = 1; ev_mm_err = 1; step(); ev_underrun = 0; ev_mm_err = 0;
        rd(A_EVT, v); check("R7 un mme", {30'b0, v[11:10]}, 3);

        st_not_empty = 1; step();
        rd(A_EVT, v); check("R8 ne live", v[9], 1);
        wr(A_EVT, 32'hFFFF_FFFF);
        rd(A_EVT, v); check("R8 write ignored", v[9], 1);
        st_not_empty = 0; step();
        rd(A_EVT, v); check("R8 ne low", v[9], 0);

        wr(A_MASK, 32'h8000_0000);
        st_busy = 1; step();
        check("R9 tip pulse", {31'b0, irq}, 1);
        step();
        check("R9 tip held", {31'b0, irq}, 0);

        rd(8'h10, v); check("R11 unmapped", v, 0);
        rd(8'hFC, v); check("R11 unmapped top", v, 0);
        step();
        summary();
    end
endmodule